// File: doc/BRIEF.md
# Supply Over-Voltage Interrupt Supervisor

This block supervises the over-voltage state of a multi-channel switch-monitoring front end. It takes a single over-voltage level, with the hysteresis already applied upstream, and passes it through a two-flop synchronizer. Entry into over-voltage and exit from it are detected as edges of the synchronized level. On entry, the block stops the channel polling sequencer and switches off every channel bias (current source or sink) enable. On entry and again on exit, it raises an interrupt-status bit and pulls the active-low interrupt output low. A separate live status bit follows the over-voltage state.

The block also contains the polling sequencer. The sequencer visits each enabled channel in ascending order and holds each one for a fixed dwell time. It samples each switch at the end of that channel's dwell. At the end of each full scan, it compares the results with the stored switch status. A difference raises a switch-state-change interrupt.

The first scan after reset, and the first scan after recovery from over-voltage, is taken as a new baseline. That scan always raises the switch-state-change interrupt. The serial interface supplies chip-select edge events and a strobe that marks a read of the interrupt-status register. Interrupt status is cleared only at a chip-select rising edge that closes a transaction in which that register was read.

Top module: `ov_irq_supervisor`

## Requirements
- R1: While `rst` is high (sampled synchronously), `intN` is 1, `intStatOv`, `intStatSsc`, `ovStat`, `statusFlag` and `pollBusy` are 0, and `biasEn` and `swStatus` are all zeros.
- R2: `ovLevel` passes through two synchronizer flops. `ovStat` equals the value `ovLevel` had three rising clock edges earlier.
- R3: From the edge at which `ovStat` becomes 1, and for as long as it stays 1, `biasEn` is all zeros and `pollBusy` is 0.
- R4: At the edge where `ovStat` rises, `intStatOv` becomes 1 and `intN` goes low. `intN` is low exactly when `intStatOv` or `intStatSsc` is 1.
- R5: `statusFlag` is 1 whenever `ovStat` or `intStatOv` is 1, and 0 otherwise.
- R6: A `csRise` pulse clears `intStatOv` and `intStatSsc` only if `intStatRead` was pulsed since the last `csFall`, or in the same cycle as `csRise`. A `csRise` without a read changes nothing.
- R7: Once the interrupt status has been cleared during over-voltage, no further over-voltage interrupt occurs while `ovStat` stays 1.
- R8: At the edge where `ovStat` falls, `intStatOv` becomes 1 and `intN` goes low again.
- R9: At the same edge where `ovStat` falls, polling restarts. `biasEn` is then one-hot on the lowest-numbered set bit of `chanEn`, whatever the state of `intN` or the serial interface.
- R10: While polling, `biasEn` is one-hot on the active channel. Each enabled channel is held for DWELL cycles, channels are visited in ascending index order, and disabled channels are skipped. After the highest enabled channel, polling wraps to the lowest enabled channel.
- R11: At the end of a scan, `swStatus` is loaded with the sampled switch values of the enabled channels, and 0 for disabled channels. `intStatSsc` is set if that scan is the first one after reset or recovery, or if the loaded value differs from the previous `swStatus`.
- R12: While `ovStat` stays 1, `swStatus` does not change, even when `swIn` changes.
- R13: If an event (over-voltage entry, over-voltage exit or a switch-state change) occurs in the same cycle as a qualifying clear, the event's bit ends up 1 and `intN` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovLevel | input | 1 | Over-voltage level from the comparator (hysteresis already applied), asynchronous |
| chanEn | input | NCH | Channel enable mask |
| swIn | input | NCH | Raw switch comparison results, one per channel |
| csFall | input | 1 | One-cycle pulse: chip select went active (transaction start) |
| csRise | input | 1 | One-cycle pulse: chip select released (transaction end) |
| intStatRead | input | 1 | One-cycle pulse: the interrupt-status register was read in this transaction |
| intN | output | 1 | Interrupt output, active low |
| intStatOv | output | 1 | Interrupt status: over-voltage entry or exit occurred |
| intStatSsc | output | 1 | Interrupt status: switch state changed, or a new baseline was taken |
| ovStat | output | 1 | Live over-voltage status |
| statusFlag | output | 1 | Flag reported in the status field of every serial transaction |
| biasEn | output | NCH | Per-channel current source/sink enable |
| pollBusy | output | 1 | Polling sequencer is running |
| swStatus | output | NCH | Switch status captured at the end of the last scan |

## Verification
A behavioural model runs in the bench and is compared with the design on every clock. The model is driven through these input patterns:
- A steady switch pattern, to show that only the baseline scan raises a state-change interrupt.
- A changed pattern, to show that a difference is detected.
- Switch changes made during over-voltage, to separate a held `swStatus` from one that is still being refreshed.
- Transactions with a read and without one, to show that only a transaction containing a read clears the status.
- A clear timed into the exact cycle of the over-voltage exit, to show that the event takes priority over the clear.
- Mask changes, including an empty mask, to check channel skipping and the restart point.

// File: rtl/ovsup_pkg.sv
package ovsup_pkg;
  // strobes from the supervisor control to the polling datapath
  typedef struct packed {
    logic halt;   // synchronized over-voltage level: stop polling now
    logic rearm;  // over-voltage just ended: next full scan is a baseline
  } pollCtrl_t;
endpackage

// File: rtl/ovsup_ctrl.sv
module ovsup_ctrl
  import ovsup_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ovLevel,
  input  logic      csFall,
  input  logic      csRise,
  input  logic      intStatRead,
  input  logic      sscEvent,
  output pollCtrl_t pollCtl,
  output logic      intN,
  output logic      intStatOv,
  output logic      intStatSsc,
  output logic      ovStat,
  output logic      statusFlag
);
  logic syncA, syncB, ovPrevQ, readSeenQ;
  logic ovEntry, ovExit, ovEvent, clearQual;

  assign ovEntry   = syncB & ~ovPrevQ;
  assign ovExit    = ~syncB & ovPrevQ;
  assign ovEvent   = ovEntry | ovExit;
  assign clearQual = csRise & (readSeenQ | intStatRead);

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      ovPrevQ    <= 1'b0;
      readSeenQ  <= 1'b0;
      intStatOv  <= 1'b0;
      intStatSsc <= 1'b0;
    end else begin
      syncA   <= ovLevel;
      syncB   <= syncA;
      ovPrevQ <= syncB;
      if (csRise | csFall) readSeenQ <= 1'b0;
      else if (intStatRead) readSeenQ <= 1'b1;
      // a new event beats a clear in the same cycle
      intStatOv  <= ovEvent  | (intStatOv  & ~clearQual);
      intStatSsc <= sscEvent | (intStatSsc & ~clearQual);
    end
  end

  assign ovStat       = ovPrevQ;
  assign statusFlag   = ovPrevQ | intStatOv;
  assign intN         = ~(intStatOv | intStatSsc);
  assign pollCtl.halt  = syncB;
  assign pollCtl.rearm = ovExit;

  // R4 R8
  ov_edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ovStat != $past(ovStat)) |-> (intStatOv && !intN));

  // R6
  clear_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(intStatOv) || $fell(intStatSsc)) |-> $past(csRise));

  // R7
  no_repeat_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ovStat && $past(ovStat) && !$past(intStatOv)) |-> !intStatOv);

  // R13
  ssc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sscEvent) |-> intStatSsc);
endmodule

// File: rtl/ovsup_scan.sv
module ovsup_scan
  import ovsup_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DWELL = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  pollCtrl_t      pollCtl,
  input  logic [NCH-1:0] chanEn,
  input  logic [NCH-1:0] swIn,
  output logic           sscEvent,
  output logic [NCH-1:0] biasEn,
  output logic           pollBusy,
  output logic [NCH-1:0] swStatus
);
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DCW = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic           runQ, basePendQ;
  logic [CW-1:0]  chanQ, firstCh, nextCh;
  logic [DCW-1:0] dwellQ;
  logic [NCH-1:0] scanQ, scanNext, swStatusQ, freshStatus;
  logic           firstValid, nextValid, dwellDone, scanEnd;

  // lowest enabled channel, and the lowest enabled channel above the active one
  always_comb begin
    firstCh    = '0;
    firstValid = 1'b0;
    nextCh     = '0;
    nextValid  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (chanEn[i]) begin
        firstCh    = CW'(i);
        firstValid = 1'b1;
        if (CW'(i) > chanQ) begin
          nextCh    = CW'(i);
          nextValid = 1'b1;
        end
      end
    end
  end

  always_comb begin
    scanNext        = scanQ;
    scanNext[chanQ] = swIn[chanQ];
  end

  assign dwellDone   = (dwellQ == DCW'(DWELL - 1));
  assign scanEnd     = runQ & ~pollCtl.halt & dwellDone & ~nextValid;
  assign freshStatus = scanNext & chanEn;
  assign sscEvent    = scanEnd & (basePendQ | (freshStatus != swStatusQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ      <= 1'b0;
      chanQ     <= '0;
      dwellQ    <= '0;
      scanQ     <= '0;
      swStatusQ <= '0;
      basePendQ <= 1'b1;
    end else begin
      if (pollCtl.rearm) basePendQ <= 1'b1;
      else if (scanEnd)  basePendQ <= 1'b0;

      if (pollCtl.halt) begin
        runQ <= 1'b0;
      end else if (!runQ) begin
        if (firstValid) begin
          runQ   <= 1'b1;
          chanQ  <= firstCh;
          dwellQ <= '0;
        end
      end else if (dwellDone) begin
        scanQ <= scanNext;
        if (nextValid) begin
          chanQ  <= nextCh;
          dwellQ <= '0;
        end else begin
          swStatusQ <= freshStatus;
          runQ      <= firstValid;
          chanQ     <= firstCh;
          dwellQ    <= '0;
        end
      end else begin
        dwellQ <= dwellQ + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_bias
    assign biasEn[g] = runQ && (chanQ == CW'(g));
  end

  assign pollBusy = runQ;
  assign swStatus = swStatusQ;

  // R10
  bias_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(biasEn));

  // R10
  dwell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(runQ) && !$past(dwellDone) && !$past(pollCtl.halt)) |-> $stable(biasEn));
endmodule

// File: rtl/ov_irq_supervisor.sv
module ov_irq_supervisor
  import ovsup_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DWELL = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ovLevel,
  input  logic [NCH-1:0] chanEn,
  input  logic [NCH-1:0] swIn,
  input  logic           csFall,
  input  logic           csRise,
  input  logic           intStatRead,
  output logic           intN,
  output logic           intStatOv,
  output logic           intStatSsc,
  output logic           ovStat,
  output logic           statusFlag,
  output logic [NCH-1:0] biasEn,
  output logic           pollBusy,
  output logic [NCH-1:0] swStatus
);
  pollCtrl_t pollCtl;
  logic      sscEvent;

  ovsup_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ovLevel(ovLevel), .csFall(csFall), .csRise(csRise),
    .intStatRead(intStatRead), .sscEvent(sscEvent), .pollCtl(pollCtl),
    .intN(intN), .intStatOv(intStatOv), .intStatSsc(intStatSsc),
    .ovStat(ovStat), .statusFlag(statusFlag)
  );

  ovsup_scan #(.NCH(NCH), .DWELL(DWELL)) u_scan (
    .clk(clk), .rst(rst), .pollCtl(pollCtl), .chanEn(chanEn), .swIn(swIn),
    .sscEvent(sscEvent), .biasEn(biasEn), .pollBusy(pollBusy), .swStatus(swStatus)
  );

  // R3
  ov_bias_off_chk: assert property (@(posedge clk) disable iff (rst)
    ovStat |-> (biasEn == '0 && !pollBusy));

  // R12
  ov_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovStat && $past(ovStat)) |-> $stable(swStatus));
endmodule

// File: tb/tb_ov_irq_supervisor.sv
module tb_ov_irq_supervisor;
  localparam int NCH = 8;
  localparam int DW  = 2;

  logic clk = 1'b0, rst = 1'b1, ovLevel = 1'b0;
  logic [NCH-1:0] chanEn = 8'b1010_0110, swIn = 8'b0000_0100;
  logic csFall = 1'b0, csRise = 1'b0, intStatRead = 1'b0;
  logic intN, intStatOv, intStatSsc, ovStat, statusFlag, pollBusy;
  logic [NCH-1:0] biasEn, swStatus;

  int checks = 0, fails = 0;
  bit cmpOn = 0, done = 0;

  always #4 clk = ~clk;

  ov_irq_supervisor #(.NCH(NCH), .DWELL(DW)) dut (
    .clk(clk), .rst(rst), .ovLevel(ovLevel), .chanEn(chanEn), .swIn(swIn),
    .csFall(csFall), .csRise(csRise), .intStatRead(intStatRead),
    .intN(intN), .intStatOv(intStatOv), .intStatSsc(intStatSsc), .ovStat(ovStat),
    .statusFlag(statusFlag), .biasEn(biasEn), .pollBusy(pollBusy), .swStatus(swStatus)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mS1, mS2, mPrev, mIOv, mISsc, mRd, mRun, mChan, mCnt, mBase;
  int mScan, mSw;

  function automatic int firstEn(input int mask);
    for (int i = 0; i < NCH; i++) if (mask[i]) return i;
    return -1;
  endfunction

  function automatic int nextEn(input int mask, input int ch);
    for (int i = ch + 1; i < NCH; i++) if (mask[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mIOv = 0; mISsc = 0; mRd = 0;
      mRun = 0; mChan = 0; mCnt = 0; mBase = 1; mScan = 0; mSw = 0;
    end else begin
      int mask, ev, ssc, clr, scanN, nx, fe, endScan;
      mask = int'(chanEn);
      ev = (mS2 != mPrev);
      clr = csRise && (mRd || intStatRead);
      ssc = 0; endScan = 0;
      scanN = mScan;
      scanN[mChan] = swIn[mChan];
      nx = nextEn(mask, mChan);
      fe = firstEn(mask);
      if (mRun && !mS2 && mCnt == DW - 1 && nx < 0) begin
        endScan = 1;
        if (mBase || ((scanN & mask) != mSw)) ssc = 1;
      end
      if (ev) mIOv = 1; else if (clr) mIOv = 0;
      if (ssc) mISsc = 1; else if (clr) mISsc = 0;
      if (csRise || csFall) mRd = 0; else if (intStatRead) mRd = 1;
      if (!mS2 && mPrev) mBase = 1; else if (endScan) mBase = 0;
      if (mS2) mRun = 0;
      else if (!mRun) begin
        if (fe >= 0) begin mRun = 1; mChan = fe; mCnt = 0; end
      end else if (mCnt == DW - 1) begin
        mScan = scanN;
        if (nx >= 0) begin mChan = nx; mCnt = 0; end
        else begin
          mSw = scanN & mask;
          mRun = (fe >= 0);
          mChan = (fe >= 0) ? fe : 0;
          mCnt = 0;
        end
      end else mCnt++;
      mPrev = mS2; mS2 = mS1; mS1 = ovLevel;
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      int expBias;
      expBias = mRun ? (1 << mChan) : 0;
      check("R2 ovStat",      ovStat,      mPrev);
      check("R8 intStatOv",   intStatOv,   mIOv);
      check("R11 intStatSsc", intStatSsc,  mISsc);
      check("R4 intN",        intN,        !(mIOv || mISsc));
      check("R5 statusFlag",  statusFlag,  mPrev || mIOv);
      check("R10 biasEn",     int'(biasEn), expBias);
      check("R3 pollBusy",    pollBusy,    mRun);
      check("R12 swStatus",   int'(swStatus), mSw);
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one transaction; on return the csRise edge has been applied
  task automatic txn(input bit doRead);
    @(negedge clk) csFall = 1'b1;
    @(negedge clk) csFall = 1'b0; intStatRead = doRead;
    @(negedge clk) intStatRead = 1'b0; csRise = 1'b1;
    @(negedge clk) csRise = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmpOn = 1;
    // R1 reset state
    check("R1 intN", intN, 1);
    check("R1 status", {intStatOv, intStatSsc, ovStat, statusFlag, pollBusy}, 0);
    check("R1 biasEn/swStatus", {biasEn, swStatus}, 0);
    waitCyc(2);
    rst = 1'b0;
    waitCyc(30);                       // baseline scan completes
    check("R11 baseline ssc", intStatSsc, 1);
    txn(1'b0);
    check("R6 no read keeps status", intStatSsc, 1);
    txn(1'b1);
    check("R6 read clears status", intStatSsc, 0);
    swIn = 8'b1000_0010;
    waitCyc(20);
    check("R11 change ssc", intStatSsc, 1);
    txn(1'b1);
    waitCyc(20);
    check("R11 steady no ssc", intStatSsc, 0);
    ovLevel = 1'b1;
    waitCyc(4);
    check("R4 entry irq", {ovStat, intStatOv, intN}, 3'b110);
    swIn = 8'b0010_0100;
    txn(1'b1);
    waitCyc(20);
    check("R7 no repeat irq", intN, 1);
    check("R12 held status", int'(swStatus), 8'b1000_0010);
    @(negedge clk) csFall = 1'b1;
    @(negedge clk) csFall = 1'b0; intStatRead = 1'b1;
    @(negedge clk) intStatRead = 1'b0;
    ovLevel = 1'b0;
    waitCyc(2);
    csRise = 1'b1;                     // lands in the exit-detect cycle
    @(negedge clk) csRise = 1'b0;
    check("R13 exit beats clear", {intStatOv, intN, ovStat}, 3'b100);
    check("R9 restart first channel", int'(biasEn), 8'b0000_0010);
    waitCyc(20);
    check("R11 recovery baseline", {intStatSsc, swStatus}, {1'b1, 8'b0010_0100});
    txn(1'b1);
    chanEn = 8'b0100_1000;
    swIn = 8'b1111_1111;
    waitCyc(24);
    chanEn = 8'b0000_0000;
    waitCyc(12);
    check("R10 empty mask idle", pollBusy, 0);
    chanEn = 8'b0000_0001;
    waitCyc(12);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule